// File: doc/BRIEF.md
# Fused compare-and-branch resolution unit

This unit takes one 32-bit compare-and-branch instruction word and resolves it completely. It decodes the word, compares two register operands directly, and produces the branch outcome. The comparison is signed or unsigned, at 32-bit or 64-bit width. No condition flags are read or written.

The unit drives the two register-file read indices straight from the word, so the operands can be fetched in the same cycle. When `valid_i` is strobed, the unit captures the operands, the program counter and the word. One cycle later it presents the outcome: taken, target, next program counter and the undefined-instruction flag. These outputs are held until the next strobe.

Top module: `cbr_unit`

## Requirements
- R1: A word is recognised only when bits 30..24 equal 1110100 and bits 15..14 equal 00. Any other word yields `undef_o`=1, `taken_o`=0 and `next_pc_o` = PC+4.
- R2: When `feat_en_i` is 0, every word is flagged undefined and no branch is taken.
- R3: The condition field is bits 23..21, and the first operand is the register in bits 4..0. Code 000 tests first > second (signed). Code 001 tests first >= second (signed). Code 010 tests first > second (unsigned). Code 011 tests first >= second (unsigned).
- R4: Code 110 branches when the two operands are equal. Code 111 branches when they differ.
- R5: Codes 100 and 101 are reserved. They raise `undef_o` with `taken_o`=0, and `undef_o` never coexists with `taken_o`=1.
- R6: Bit 31 selects the width. With bit 31 at 0, only the low 32 bits of each operand are compared, bit 31 is the sign, and bits 63..32 have no effect. With bit 31 at 1, all 64 bits are compared.
- R7: A register index of 31 (first operand in bits 4..0, second in bits 20..16) reads as zero, whatever operand value is supplied.
- R8: The target is PC plus the sign-extended value of bits 13..5 shifted left by two. This covers byte offsets from -1024 to +1020.
- R9: `next_pc_o` equals `target_o` when taken, otherwise PC+4.
- R10: The outcome appears one cycle after a `valid_i` strobe, with `res_valid_o` high for that one cycle. `taken_o`, `undef_o` and `target_o` are held until the next strobe.
- R11: `rs_a_idx_o` is bits 4..0 and `rs_b_idx_o` is bits 20..16 of `insn_i`, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Strobe: capture and resolve the current word |
| insn_i | input | 32 | Instruction word |
| pc_i | input | 64 | Address of the instruction |
| op_a_i | input | 64 | Value read for the first-operand index |
| op_b_i | input | 64 | Value read for the second-operand index |
| feat_en_i | input | 1 | Compare-and-branch feature implemented |
| rs_a_idx_o | output | 5 | First-operand read index |
| rs_b_idx_o | output | 5 | Second-operand read index |
| res_valid_o | output | 1 | Outcome valid pulse |
| undef_o | output | 1 | Undefined-instruction flag |
| taken_o | output | 1 | Branch taken |
| target_o | output | 64 | Branch target address |
| next_pc_o | output | 64 | Next program counter |

## Verification
The bench sweeps all eight condition codes at both widths. The operand pairs are chosen so that a mix-up between signed and unsigned shows up: the most-negative value against the most-positive flips the result. A design that reads bits 63..32 in narrow mode, or takes the sign from bit 63, fails the pair whose low halves are equal but whose upper halves differ. Reserved codes, a disabled feature and broken opcode bits must all flag undefined and fall through to PC+4. The zero-register index must override a non-zero supplied operand. The two extreme offsets expose a missing sign extension or a wrong shift.

// File: rtl/cbr_pkg.sv
package cbr_pkg;
  localparam int unsigned INSN_W  = 32;
  localparam int unsigned IDX_W   = 5;
  localparam int unsigned IMM_W   = 9;
  localparam int unsigned SF_BIT  = 31;
  localparam int unsigned OPC_LO  = 24;
  localparam int unsigned CC_LO   = 21;
  localparam int unsigned RM_LO   = 16;
  localparam int unsigned PAD_LO  = 14;
  localparam int unsigned IMM_LO  = 5;
  localparam int unsigned RT_LO   = 0;
  localparam logic [6:0]  OPC_VAL = 7'b1110100;
  localparam logic [IDX_W-1:0] ZERO_IDX = '1;

  typedef enum logic [1:0] {
    CMP_GT = 2'd0,
    CMP_GE = 2'd1,
    CMP_EQ = 2'd2,
    CMP_NE = 2'd3
  } cmp_op_e;

  typedef struct packed {
    logic             undef;
    logic             wide;
    logic             is_signed;
    cmp_op_e          op;
    logic [IDX_W-1:0] rt;
    logic [IDX_W-1:0] rm;
    logic [IMM_W-1:0] imm;
  } dec_t;
endpackage

// File: rtl/cbr_decode.sv
module cbr_decode
  import cbr_pkg::*;
(
  input  logic [INSN_W-1:0] insn_i,
  input  logic              feat_en_i,
  output dec_t              dec_o
);
  logic       match;
  logic [2:0] cc;
  logic       rsvd;

  assign cc    = insn_i[CC_LO +: 3];
  assign match = (insn_i[OPC_LO +: 7] == OPC_VAL) && (insn_i[PAD_LO +: 2] == 2'b00);

  always_comb begin
    rsvd            = 1'b0;
    dec_o.is_signed = 1'b0;
    dec_o.op        = CMP_EQ;
    unique case (cc)
      3'b000:  begin dec_o.op = CMP_GT; dec_o.is_signed = 1'b1; end
      3'b001:  begin dec_o.op = CMP_GE; dec_o.is_signed = 1'b1; end
      3'b010:  dec_o.op = CMP_GT;
      3'b011:  dec_o.op = CMP_GE;
      3'b110:  dec_o.op = CMP_EQ;
      3'b111:  dec_o.op = CMP_NE;
      default: rsvd = 1'b1;
    endcase
  end

  assign dec_o.undef = !match || !feat_en_i || rsvd;
  assign dec_o.wide  = insn_i[SF_BIT];
  assign dec_o.rt    = insn_i[RT_LO +: IDX_W];
  assign dec_o.rm    = insn_i[RM_LO +: IDX_W];
  assign dec_o.imm   = insn_i[IMM_LO +: IMM_W];
endmodule

// File: rtl/cbr_compare.sv
module cbr_compare
  import cbr_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0]  op_a_i,
  input  logic [XLEN-1:0]  op_b_i,
  input  logic [IDX_W-1:0] idx_a_i,
  input  logic [IDX_W-1:0] idx_b_i,
  input  logic             wide_i,
  input  logic             is_signed_i,
  input  cmp_op_e          op_i,
  output logic             hit_o
);
  localparam int unsigned HALF = XLEN / 2;
  localparam int unsigned NOPS = 2;

  logic [XLEN-1:0]  raw [NOPS];
  logic [IDX_W-1:0] idx [NOPS];
  logic [XLEN-1:0]  opnd [NOPS];
  logic [XLEN:0]    ext  [NOPS];

  assign raw[0] = op_a_i;
  assign raw[1] = op_b_i;
  assign idx[0] = idx_a_i;
  assign idx[1] = idx_b_i;

  for (genvar g = 0; g < NOPS; g++) begin : g_opnd
    logic sgn;
    assign opnd[g] = (idx[g] == ZERO_IDX) ? '0 : raw[g];
    assign sgn     = is_signed_i && (wide_i ? opnd[g][XLEN-1] : opnd[g][HALF-1]);
    // one extra bit so a single signed compare serves both signednesses
    assign ext[g]  = wide_i ? {sgn, opnd[g]}
                            : {{(XLEN-HALF+1){sgn}}, opnd[g][HALF-1:0]};
  end

  logic gt, eq;
  assign gt = $signed(ext[0]) > $signed(ext[1]);
  assign eq = ext[0] == ext[1];

  always_comb begin
    unique case (op_i)
      CMP_GT: hit_o = gt;
      CMP_GE: hit_o = gt || eq;
      CMP_EQ: hit_o = eq;
      CMP_NE: hit_o = !eq;
      default: hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/cbr_target.sv
module cbr_target #(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned IMM_W = 9
) (
  input  logic [XLEN-1:0]  pc_i,
  input  logic [IMM_W-1:0] imm_i,
  output logic [XLEN-1:0]  target_o,
  output logic [XLEN-1:0]  seq_o
);
  localparam int unsigned OFF_W = IMM_W + 2;
  localparam logic [XLEN-1:0] INSN_BYTES = XLEN'(4);

  logic [XLEN-1:0] offset;
  assign offset   = {{(XLEN-OFF_W){imm_i[IMM_W-1]}}, imm_i, 2'b00};
  assign target_o = pc_i + offset;
  assign seq_o    = pc_i + INSN_BYTES;
endmodule

// File: rtl/cbr_unit.sv
module cbr_unit
  import cbr_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [INSN_W-1:0]   insn_i,
  input  logic [XLEN-1:0]     pc_i,
  input  logic [XLEN-1:0]     op_a_i,
  input  logic [XLEN-1:0]     op_b_i,
  input  logic                feat_en_i,
  output logic [IDX_W-1:0]    rs_a_idx_o,
  output logic [IDX_W-1:0]    rs_b_idx_o,
  output logic                res_valid_o,
  output logic                undef_o,
  output logic                taken_o,
  output logic [XLEN-1:0]     target_o,
  output logic [XLEN-1:0]     next_pc_o
);
  dec_t            dec;
  logic            hit;
  logic            take_d;
  logic [XLEN-1:0] tgt_d, seq_d;

  cbr_decode u_dec (
    .insn_i    (insn_i),
    .feat_en_i (feat_en_i),
    .dec_o     (dec)
  );

  cbr_compare #(.XLEN(XLEN)) u_cmp (
    .op_a_i      (op_a_i),
    .op_b_i      (op_b_i),
    .idx_a_i     (dec.rt),
    .idx_b_i     (dec.rm),
    .wide_i      (dec.wide),
    .is_signed_i (dec.is_signed),
    .op_i        (dec.op),
    .hit_o       (hit)
  );

  cbr_target #(.XLEN(XLEN), .IMM_W(IMM_W)) u_tgt (
    .pc_i     (pc_i),
    .imm_i    (dec.imm),
    .target_o (tgt_d),
    .seq_o    (seq_d)
  );

  assign rs_a_idx_o = dec.rt;
  assign rs_b_idx_o = dec.rm;
  assign take_d     = hit && !dec.undef;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      undef_o     <= 1'b0;
      taken_o     <= 1'b0;
      target_o    <= '0;
      next_pc_o   <= '0;
    end else begin
      res_valid_o <= valid_i;
      if (valid_i) begin
        undef_o   <= dec.undef;
        taken_o   <= take_d;
        target_o  <= tgt_d;
        next_pc_o <= take_d ? tgt_d : seq_d;
      end
    end
  end
endmodule

// File: rtl/cbr_unit_chk.sv
module cbr_unit_chk #(
  parameter int unsigned XLEN = 64
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            valid_i,
  input logic            feat_en_i,
  input logic [6:0]      opc_i,
  input logic [XLEN-1:0] pc_i,
  input logic            res_valid_o,
  input logic            undef_o,
  input logic            taken_o,
  input logic [XLEN-1:0] target_o,
  input logic [XLEN-1:0] next_pc_o
);
  // R5
  undef_no_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    undef_o |-> !taken_o);

  // R9
  next_pc_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && taken_o |-> next_pc_o == target_o);

  // R9
  next_pc_seq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && !taken_o |-> next_pc_o == $past(pc_i) + XLEN'(4));

  // R2
  feat_off_undef_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && !$past(feat_en_i) |-> undef_o);

  // R1
  bad_opc_undef_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && ($past(opc_i) != 7'b1110100) |-> undef_o);

  // R10
  result_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> res_valid_o);

  // R10
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !res_valid_o && $stable(taken_o) && $stable(undef_o) && $stable(target_o));
endmodule

bind cbr_unit cbr_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .feat_en_i   (feat_en_i),
  .opc_i       (insn_i[30:24]),
  .pc_i        (pc_i),
  .res_valid_o (res_valid_o),
  .undef_o     (undef_o),
  .taken_o     (taken_o),
  .target_o    (target_o),
  .next_pc_o   (next_pc_o)
);

// File: tb/cbr_unit_bench.sv
module cbr_unit_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] insn_i = '0;
  logic [63:0] pc_i = '0, op_a_i = '0, op_b_i = '0;
  logic        feat_en_i = 1'b1;
  logic [4:0]  rs_a_idx_o, rs_b_idx_o;
  logic        res_valid_o, undef_o, taken_o;
  logic [63:0] target_o, next_pc_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  cbr_unit u_cbr_unit (
    .clk_i, .rst_ni, .valid_i, .insn_i, .pc_i, .op_a_i, .op_b_i, .feat_en_i,
    .rs_a_idx_o, .rs_b_idx_o, .res_valid_o, .undef_o, .taken_o, .target_o, .next_pc_o
  );

  typedef struct {
    string       req;
    logic        tk;
    logic        ud;
    logic [63:0] tgt;
    logic [63:0] npc;
  } exp_t;

  exp_t sb_q[$];

  function automatic logic [31:0] mk(bit sf, bit [2:0] cc, bit [4:0] rm, int off, bit [4:0] rt);
    logic [10:0] o;
    o = off[10:0];
    return {sf, 7'b1110100, cc, rm, 2'b00, o[10:2], rt};
  endfunction

  function automatic exp_t model(logic [31:0] w, logic [63:0] pc, logic [63:0] a,
                                 logic [63:0] b, logic fe);
    exp_t e;
    logic ok, tk;
    logic [2:0] c;
    longint sa, sb;
    logic [63:0] ua, ub;
    c  = w[23:21];
    ok = fe && (w[30:24] == 7'b1110100) && (w[15:14] == 2'b00) && (c != 3'b100) && (c != 3'b101);
    if (w[4:0] == 5'd31) a = '0;
    if (w[20:16] == 5'd31) b = '0;
    if (w[31]) begin
      ua = a; ub = b; sa = $signed(a); sb = $signed(b);
    end else begin
      ua = {32'd0, a[31:0]}; ub = {32'd0, b[31:0]};
      sa = longint'($signed(a[31:0])); sb = longint'($signed(b[31:0]));
    end
    case (c)
      3'b000: tk = sa > sb;
      3'b001: tk = sa >= sb;
      3'b010: tk = ua > ub;
      3'b011: tk = ua >= ub;
      3'b110: tk = ua == ub;
      3'b111: tk = ua != ub;
      default: tk = 1'b0;
    endcase
    e.req = "";
    e.ud  = !ok;
    e.tk  = tk && ok;
    e.tgt = pc + 64'(longint'($signed({w[13:5], 2'b00})));
    e.npc = e.tk ? e.tgt : pc + 64'd4;
    return e;
  endfunction

  task automatic check(string req, bit ok, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(string req, logic [31:0] w, logic [63:0] pc, logic [63:0] a,
                       logic [63:0] b, logic fe);
    exp_t e;
    @(negedge clk_i);
    insn_i = w; pc_i = pc; op_a_i = a; op_b_i = b; feat_en_i = fe; valid_i = 1'b1;
    e = model(w, pc, a, b, fe);
    e.req = req;
    sb_q.push_back(e);
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk_i);
      valid_i = 1'b0;
    end
  endtask

  task automatic drain();
    idle(1);
    while (sb_q.size() != 0) @(negedge clk_i);
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (rst_ni && res_valid_o) begin
      if (sb_q.size() == 0) begin
        check("R10", 1'b0, "unexpected result", 64'(res_valid_o), 64'd0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(e.req, taken_o == e.tk && undef_o == e.ud && next_pc_o == e.npc
              && (e.ud || target_o == e.tgt),
              "taken/undef/next_pc", {undef_o, taken_o, next_pc_o[61:0]},
              {e.ud, e.tk, e.npc[61:0]});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  logic [63:0] pa [4] = '{64'hFFFF_0000_0000_0005, 64'h8000_0000_8000_0000,
                          64'h7FFF_FFFF_7FFF_FFFF, 64'hAAAA_0000_0000_0003};
  logic [63:0] pb [4] = '{64'h0000_1234_0000_0005, 64'h7FFF_FFFF_7FFF_FFFF,
                          64'h8000_0000_8000_0000, 64'h0000_5555_0000_0007};

  initial begin
    logic hold_tk, hold_ud;
    logic [63:0] hold_tgt;
    repeat (3) @(negedge clk_i);
    // R10 reset state
    check("R10", !res_valid_o && !taken_o && !undef_o && next_pc_o == 0,
          "reset outputs", {res_valid_o, taken_o, undef_o}, 64'd0);
    rst_ni = 1'b1;

    // R11 read indices
    insn_i = mk(1'b1, 3'b000, 5'd22, 0, 5'd9);
    #1;
    check("R11", rs_a_idx_o == 5'd9 && rs_b_idx_o == 5'd22, "read indices",
          {rs_a_idx_o, rs_b_idx_o}, {5'd9, 5'd22});

    // R3 R4 R5 R6 sweep
    for (int sf = 0; sf < 2; sf++)
      for (int cc = 0; cc < 8; cc++)
        for (int p = 0; p < 4; p++) begin
          string tag;
          if (cc == 4 || cc == 5) tag = "R5";
          else if (cc >= 6) tag = "R4";
          else tag = "R3";
          if (sf == 0 && p == 0) tag = "R6";
          drive(tag, mk(sf[0], cc[2:0], 5'd2, 8 * (p + 1), 5'd1),
                64'h0000_0040_0000_1000 + 64'(cc * 16), pa[p], pb[p], 1'b1);
          if (p == 3) idle(1);
        end
    drain();

    // R6 narrow signed: upper bits ignored, bit 31 as sign
    drive("R6", mk(1'b0, 3'b000, 5'd4, 4, 5'd3), 64'h2000, 64'h0000_0001_0000_0000,
          64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
    drive("R6", mk(1'b1, 3'b000, 5'd4, 4, 5'd3), 64'h2000, 64'h0000_0001_0000_0000,
          64'h0000_0000_FFFF_FFFF, 1'b1);

    // R7 zero register
    drive("R7", mk(1'b1, 3'b110, 5'd5, 12, 5'd31), 64'h3000, 64'hDEAD_BEEF, 64'd0, 1'b1);
    drive("R7", mk(1'b1, 3'b110, 5'd31, 12, 5'd6), 64'h3000, 64'd0, 64'h1234, 1'b1);
    drive("R7", mk(1'b0, 3'b111, 5'd31, 12, 5'd31), 64'h3000, 64'h77, 64'h99, 1'b1);

    // R1 bad encodings
    drive("R1", mk(1'b1, 3'b110, 5'd2, 16, 5'd1) ^ 32'h0100_0000, 64'h4000, 64'd1, 64'd1, 1'b1);
    drive("R1", mk(1'b1, 3'b110, 5'd2, 16, 5'd1) | 32'h0000_4000, 64'h4000, 64'd1, 64'd1, 1'b1);

    // R2 feature disabled
    drive("R2", mk(1'b1, 3'b110, 5'd2, 16, 5'd1), 64'h5000, 64'd7, 64'd7, 1'b0);
    drive("R2", mk(1'b0, 3'b111, 5'd2, 16, 5'd1), 64'h5000, 64'd7, 64'd8, 1'b0);

    // R9 not taken falls through
    drive("R9", mk(1'b1, 3'b110, 5'd2, 64, 5'd1), 64'h6000, 64'd1, 64'd2, 1'b1);
    drain();

    // R8 extreme offsets, checked against literal targets
    drive("R8", mk(1'b1, 3'b110, 5'd2, -1024, 5'd1), 64'h0001_0000, 64'd3, 64'd3, 1'b1);
    drain();
    check("R8", target_o == 64'h0000_FC00 && next_pc_o == 64'h0000_FC00, "offset -1024",
          target_o, 64'h0000_FC00);
    drive("R8", mk(1'b1, 3'b110, 5'd2, 1020, 5'd1), 64'h0001_0000, 64'd3, 64'd3, 1'b1);
    drain();
    check("R8", target_o == 64'h0001_03FC && next_pc_o == 64'h0001_03FC, "offset +1020",
          target_o, 64'h0001_03FC);

    // R10 hold while inputs change without strobe
    hold_tk = taken_o; hold_ud = undef_o; hold_tgt = target_o;
    insn_i = mk(1'b1, 3'b111, 5'd2, -400, 5'd1); pc_i = 64'h9999; op_a_i = 1; op_b_i = 2;
    repeat (3) @(negedge clk_i);
    check("R10", taken_o == hold_tk && undef_o == hold_ud && target_o == hold_tgt
          && !res_valid_o, "hold", target_o, hold_tgt);

    drain();
    check("R10", sb_q.size() == 0, "scoreboard drained", 64'(sb_q.size()), 64'd0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule